// File: doc/BRIEF.md
# Error-Record Group Security Access Filter

This block sits between a memory-mapped register bus and a group of error-record and interrupt-configuration registers. Each access arrives with a two-bit requester security state. The filter decides in the same cycle whether the access reaches the register group in full, reaches it for reads only, or is turned into read-as-zero with the write dropped. It also holds the 64-bit permission word that drives this decision, at offset 0xE40 of the group window.

The permission word has one two-bit code per security state. The Non-secure code is in bits 1:0, the Secure code in bits 3:2 and the Realm code in bits 5:4. Bit 31 always reads 1 to show that the word is present. Bits 30:6 read 0. Bits 63:32 are plain storage. A group status register at a parameter offset stays readable to every state that exists.

Each access is sorted into one of seven named verdicts, and a single output process acts on the verdict:
- V_IDLE: no request.
- V_CFG_OPEN: the permission word is accessed by its owner.
- V_CFG_HIDDEN: the permission word is accessed by any other state.
- V_STATUS: a read of the status register.
- V_PASS_RW: forwarded for reads and writes.
- V_PASS_RO: reads forwarded, writes dropped.
- V_BLOCKED: read as zero, write dropped.

The verdict is recomputed from the inputs in every cycle. There are no transitions between verdicts. The only sequential state is the stored permission word.

Top module: `errgrp_access_filter`

## Requirements
- R1: On cold reset, bits 5:0 take the parameter RST_PERM and bits 63:32 clear to zero. A one-cycle recov_clr pulse reloads only bits 5:0 from RST_PERM.
- R2: A code of 00 or 10 blocks its state. A guarded read returns zero with grp_valid low. A guarded write drives no grp_valid.
- R3: A code of 01 forwards reads with the group's data and drops writes. A dropped write leaves grp_valid low.
- R4: A code of 11 forwards reads and writes. grp_write follows req_write, and the read data equals grp_rdata.
- R5: A Root requester (req_sec=11) reaches every guarded register read-write, whatever the stored codes are.
- R6: A read of the permission word returns the following layout: bits 63:32 as stored, bit 31 as 1, bits 30:6 as 0, bits 5:0 as stored. Writes to bits 31:6 are ignored. A write takes effect from the next cycle.
- R7: The permission word reads as zero and ignores writes for requesters other than its owner. With HAS_REALM=1 the owner is Root only. With HAS_REALM=0 the owner is Secure or Root.
- R8: With HAS_REALM=1 and SPLIT_FIELDS=0, the Non-secure code governs Non-secure, Secure and Realm requesters. Bits 5:2 then read 0 and ignore writes.
- R9: A read of the status register (STAT_OFS) is forwarded for every existing state, even one whose code blocks it. Writes to it follow the state's code.
- R10: The filter adds no wait cycle: the read data and strobes depend on the same cycle's request. An access to the permission word never raises grp_valid.
- R11: With HAS_REALM=0, Secure has full access. A Realm requester (req_sec=10) is blocked everywhere, including the status register. Bits 5:2 read 0.
- R12: The reserved code 10 is stored as written and reads back as 10.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Cold reset, active low, asynchronous |
| recov_clr | input | 1 | Error-recovery reset pulse, synchronous |
| req_valid | input | 1 | Request strobe |
| req_write | input | 1 | 1 for write, 0 for read |
| req_sec | input | 2 | Security state: 00 Non-secure, 01 Secure, 10 Realm, 11 Root |
| req_addr | input | ADDR_W | Offset within the group window |
| req_wdata | input | 64 | Write data |
| rsp_rdata | output | 64 | Filtered read data, same cycle |
| grp_valid | output | 1 | Access strobe to the register group |
| grp_write | output | 1 | Write qualifier to the register group |
| grp_addr | output | ADDR_W | Offset to the register group |
| grp_wdata | output | 64 | Write data to the register group |
| grp_rdata | input | 64 | Read data from the register group |

## Verification
The filter is combinational apart from the permission word, so any wrong decision shows at the ports in the same cycle as the request. A wrong decision appears as a stray or missing grp_valid, a grp_write that does not match the request, or read data that is neither zero nor grp_rdata. A corrupted stored code shows up one cycle after the write that set it, on the next read of the permission word or of a guarded register. The bench covers this by sweeping all 64 code combinations against every requester state, in three configurations.

// File: rtl/eaf_pkg.sv
package eaf_pkg;

    localparam int CFG_W   = 64;
    localparam int PERM_W  = 6;

    typedef enum logic [1:0] {
        SEC_NS    = 2'b00,
        SEC_S     = 2'b01,
        SEC_REALM = 2'b10,
        SEC_ROOT  = 2'b11
    } sec_e;

    typedef enum logic [1:0] {
        LVL_NONE = 2'd0,
        LVL_RO   = 2'd1,
        LVL_RW   = 2'd2
    } level_e;

    typedef enum logic [2:0] {
        V_IDLE       = 3'd0,
        V_CFG_OPEN   = 3'd1,
        V_CFG_HIDDEN = 3'd2,
        V_STATUS     = 3'd3,
        V_PASS_RW    = 3'd4,
        V_PASS_RO    = 3'd5,
        V_BLOCKED    = 3'd6
    } verdict_e;

    // 11 -> read-write, 01 -> read-only, 00 and reserved 10 -> blocked
    function automatic level_e code_to_level(input logic [1:0] code);
        level_e lvl;
        case (code)
            2'b11:   lvl = LVL_RW;
            2'b01:   lvl = LVL_RO;
            default: lvl = LVL_NONE;
        endcase
        return lvl;
    endfunction

endpackage

// File: rtl/eaf_cfg_store.sv
module eaf_cfg_store
    import eaf_pkg::*;
#(
    parameter bit                SPLIT    = 1'b1,
    parameter logic [PERM_W-1:0] RST_PERM = 6'b11_01_11
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             recov_clr,
    input  logic             we,
    input  logic [CFG_W-1:0] wdata,
    output logic [CFG_W-1:0] word,
    output logic [1:0]       ns_code,
    output logic [1:0]       s_code,
    output logic [1:0]       r_code
);

    localparam int HI_W  = CFG_W / 2;
    localparam int GAP_W = HI_W - 1 - PERM_W;

    logic [1:0]      ns_q;
    logic [HI_W-1:0] hi_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ns_q <= RST_PERM[1:0];
            hi_q <= '0;
        end else if (recov_clr) begin
            ns_q <= RST_PERM[1:0];
        end else if (we) begin
            ns_q <= wdata[1:0];
            hi_q <= wdata[CFG_W-1:HI_W];
        end
    end

    assign ns_code = ns_q;

    generate
        if (SPLIT) begin : g_split
            logic [1:0] s_q;
            logic [1:0] r_q;
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) begin
                    s_q <= RST_PERM[3:2];
                    r_q <= RST_PERM[5:4];
                end else if (recov_clr) begin
                    s_q <= RST_PERM[3:2];
                    r_q <= RST_PERM[5:4];
                end else if (we) begin
                    s_q <= wdata[3:2];
                    r_q <= wdata[5:4];
                end
            end
            assign s_code = s_q;
            assign r_code = r_q;
        end else begin : g_shared
            assign s_code = 2'b00;
            assign r_code = 2'b00;
        end
    endgenerate

    assign word = {hi_q, 1'b1, {GAP_W{1'b0}}, r_code, s_code, ns_q};

endmodule

// File: rtl/eaf_perm_select.sv
module eaf_perm_select
    import eaf_pkg::*;
#(
    parameter bit HAS_REALM = 1'b1,
    parameter bit SPLIT     = 1'b1
) (
    input  sec_e       sec,
    input  logic [1:0] ns_code,
    input  logic [1:0] s_code,
    input  logic [1:0] r_code,
    output level_e     level,
    output logic       state_ok,
    output logic       cfg_ok
);

    always_comb begin
        state_ok = HAS_REALM || (sec != SEC_REALM);
        cfg_ok   = (sec == SEC_ROOT) || (!HAS_REALM && (sec == SEC_S));
        unique case (sec)
            SEC_ROOT: level = LVL_RW;
            SEC_NS:   level = code_to_level(ns_code);
            SEC_S: begin
                if (!HAS_REALM)  level = LVL_RW;
                else if (SPLIT)  level = code_to_level(s_code);
                else             level = code_to_level(ns_code);
            end
            SEC_REALM: begin
                if (!HAS_REALM)  level = LVL_NONE;
                else if (SPLIT)  level = code_to_level(r_code);
                else             level = code_to_level(ns_code);
            end
            default: level = LVL_NONE;
        endcase
    end

endmodule

// File: rtl/eaf_verdict.sv
module eaf_verdict
    import eaf_pkg::*;
#(
    parameter int                ADDR_W   = 12,
    parameter logic [ADDR_W-1:0] CFG_OFS  = 12'hE40,
    parameter logic [ADDR_W-1:0] STAT_OFS = 12'hE00
) (
    input  logic              req_valid,
    input  logic              req_write,
    input  logic [ADDR_W-1:0] req_addr,
    input  level_e            level,
    input  logic              state_ok,
    input  logic              cfg_ok,
    output verdict_e          verdict
);

    logic hit_cfg;
    logic hit_stat;

    assign hit_cfg  = (req_addr == CFG_OFS);
    assign hit_stat = (req_addr == STAT_OFS);

    always_comb begin
        if (!req_valid)
            verdict = V_IDLE;
        else if (hit_cfg)
            verdict = cfg_ok ? V_CFG_OPEN : V_CFG_HIDDEN;
        else if (hit_stat && !req_write && state_ok)
            verdict = V_STATUS;
        else begin
            unique case (level)
                LVL_RW:  verdict = V_PASS_RW;
                LVL_RO:  verdict = V_PASS_RO;
                default: verdict = V_BLOCKED;
            endcase
        end
    end

endmodule

// File: rtl/errgrp_access_filter.sv
module errgrp_access_filter
    import eaf_pkg::*;
#(
    parameter int                ADDR_W       = 12,
    parameter logic [ADDR_W-1:0] CFG_OFS      = 12'hE40,
    parameter logic [ADDR_W-1:0] STAT_OFS     = 12'hE00,
    parameter bit                HAS_REALM    = 1'b1,
    parameter bit                SPLIT_FIELDS = 1'b1,
    parameter logic [5:0]        RST_PERM     = 6'b11_01_11
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              recov_clr,
    input  logic              req_valid,
    input  logic              req_write,
    input  logic [1:0]        req_sec,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [63:0]       req_wdata,
    output logic [63:0]       rsp_rdata,
    output logic              grp_valid,
    output logic              grp_write,
    output logic [ADDR_W-1:0] grp_addr,
    output logic [63:0]       grp_wdata,
    input  logic [63:0]       grp_rdata
);

    localparam bit SPLIT_EFF = HAS_REALM && SPLIT_FIELDS;

    logic [CFG_W-1:0] cfg_word;
    logic [1:0]       ns_code, s_code, r_code;
    logic             cfg_we;
    level_e           level;
    logic             state_ok, cfg_ok;
    verdict_e         verdict;

    eaf_cfg_store #(
        .SPLIT    (SPLIT_EFF),
        .RST_PERM (RST_PERM)
    ) u_store (
        .clk       (clk),
        .rst_n     (rst_n),
        .recov_clr (recov_clr),
        .we        (cfg_we),
        .wdata     (req_wdata),
        .word      (cfg_word),
        .ns_code   (ns_code),
        .s_code    (s_code),
        .r_code    (r_code)
    );

    eaf_perm_select #(
        .HAS_REALM (HAS_REALM),
        .SPLIT     (SPLIT_EFF)
    ) u_perm (
        .sec      (sec_e'(req_sec)),
        .ns_code  (ns_code),
        .s_code   (s_code),
        .r_code   (r_code),
        .level    (level),
        .state_ok (state_ok),
        .cfg_ok   (cfg_ok)
    );

    eaf_verdict #(
        .ADDR_W   (ADDR_W),
        .CFG_OFS  (CFG_OFS),
        .STAT_OFS (STAT_OFS)
    ) u_verdict (
        .req_valid (req_valid),
        .req_write (req_write),
        .req_addr  (req_addr),
        .level     (level),
        .state_ok  (state_ok),
        .cfg_ok    (cfg_ok),
        .verdict   (verdict)
    );

    assign grp_addr  = req_addr;
    assign grp_wdata = req_wdata;

    // Output process: one action per verdict
    always_comb begin
        grp_valid = 1'b0;
        grp_write = 1'b0;
        rsp_rdata = '0;
        cfg_we    = 1'b0;
        unique case (verdict)
            V_IDLE, V_CFG_HIDDEN, V_BLOCKED: begin
            end
            V_CFG_OPEN: begin
                cfg_we = req_write;
                if (!req_write) rsp_rdata = cfg_word;
            end
            V_STATUS: begin
                grp_valid = 1'b1;
                rsp_rdata = grp_rdata;
            end
            V_PASS_RW: begin
                grp_valid = 1'b1;
                grp_write = req_write;
                if (!req_write) rsp_rdata = grp_rdata;
            end
            V_PASS_RO: begin
                if (!req_write) begin
                    grp_valid = 1'b1;
                    rsp_rdata = grp_rdata;
                end
            end
            default: begin
            end
        endcase
    end

endmodule

// File: rtl/eaf_checker.sv
module eaf_checker #(
    parameter int                ADDR_W    = 12,
    parameter logic [ADDR_W-1:0] CFG_OFS   = 12'hE40,
    parameter logic [ADDR_W-1:0] STAT_OFS  = 12'hE00,
    parameter bit                HAS_REALM = 1'b1
) (
    input logic              clk,
    input logic              rst_n,
    input logic              req_valid,
    input logic              req_write,
    input logic [1:0]        req_sec,
    input logic [ADDR_W-1:0] req_addr,
    input logic [63:0]       rsp_rdata,
    input logic              grp_valid,
    input logic              grp_write,
    input logic [63:0]       grp_rdata
);

    assert_idle_quiet_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !req_valid |-> (!grp_valid && rsp_rdata == 64'd0));

    assert_cfg_local_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_addr == CFG_OFS) |-> !grp_valid);

    assert_root_through_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_sec == 2'b11 && req_addr != CFG_OFS)
        |-> (grp_valid && grp_write == req_write));

    assert_ns_cfg_hidden_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && !req_write && req_sec == 2'b00 && req_addr == CFG_OFS)
        |-> rsp_rdata == 64'd0);

    assert_present_bit_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && !req_write && req_sec == 2'b11 && req_addr == CFG_OFS)
        |-> (rsp_rdata[31] && rsp_rdata[30:6] == 25'd0));

    assert_read_data_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && !req_write && grp_valid)
        |-> (!grp_write && rsp_rdata == grp_rdata));

    assert_status_open_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && !req_write && req_addr == STAT_OFS
         && (HAS_REALM || req_sec != 2'b10)) |-> grp_valid);

    assert_strobe_origin_R3: assert property (@(posedge clk) disable iff (!rst_n)
        grp_valid |-> (req_valid && grp_write == req_write));

endmodule

bind errgrp_access_filter eaf_checker #(
    .ADDR_W    (ADDR_W),
    .CFG_OFS   (CFG_OFS),
    .STAT_OFS  (STAT_OFS),
    .HAS_REALM (HAS_REALM)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .req_valid (req_valid),
    .req_write (req_write),
    .req_sec   (req_sec),
    .req_addr  (req_addr),
    .rsp_rdata (rsp_rdata),
    .grp_valid (grp_valid),
    .grp_write (grp_write),
    .grp_rdata (grp_rdata)
);

// File: tb/errgrp_access_filter_test.sv
module errgrp_access_filter_test;

    localparam int          ADDR_W = 12;
    localparam logic [11:0] CFG    = 12'hE40;
    localparam logic [11:0] STAT   = 12'hE00;
    localparam logic [11:0] GUARD  = 12'h018;
    localparam logic [5:0]  RSTP   = 6'b11_01_11;

    logic clk = 1'b0;
    always #4 clk = ~clk;   // 125 MHz

    logic        rst_n, recov_clr, req_valid, req_write;
    logic [1:0]  req_sec;
    logic [11:0] req_addr;
    logic [63:0] req_wdata;

    logic [63:0] rsp   [3];
    logic [63:0] grd   [3];
    logic [63:0] gwd   [3];
    logic        gv    [3];
    logic        gw    [3];
    logic [11:0] ga    [3];

    // group model: data tagged with instance number and address
    assign grd[0] = {16'hBEE0, 14'h0, 2'd0, 20'h0, ga[0]};
    assign grd[1] = {16'hBEE0, 14'h0, 2'd1, 20'h0, ga[1]};
    assign grd[2] = {16'hBEE0, 14'h0, 2'd2, 20'h0, ga[2]};

    errgrp_access_filter #(.HAS_REALM(1'b1), .SPLIT_FIELDS(1'b1), .RST_PERM(RSTP)) uut (
        .clk(clk), .rst_n(rst_n), .recov_clr(recov_clr), .req_valid(req_valid),
        .req_write(req_write), .req_sec(req_sec), .req_addr(req_addr), .req_wdata(req_wdata),
        .rsp_rdata(rsp[0]), .grp_valid(gv[0]), .grp_write(gw[0]), .grp_addr(ga[0]),
        .grp_wdata(gwd[0]), .grp_rdata(grd[0]));

    errgrp_access_filter #(.HAS_REALM(1'b1), .SPLIT_FIELDS(1'b0), .RST_PERM(RSTP)) uut_shared (
        .clk(clk), .rst_n(rst_n), .recov_clr(recov_clr), .req_valid(req_valid),
        .req_write(req_write), .req_sec(req_sec), .req_addr(req_addr), .req_wdata(req_wdata),
        .rsp_rdata(rsp[1]), .grp_valid(gv[1]), .grp_write(gw[1]), .grp_addr(ga[1]),
        .grp_wdata(gwd[1]), .grp_rdata(grd[1]));

    errgrp_access_filter #(.HAS_REALM(1'b0), .SPLIT_FIELDS(1'b1), .RST_PERM(RSTP)) uut_norealm (
        .clk(clk), .rst_n(rst_n), .recov_clr(recov_clr), .req_valid(req_valid),
        .req_write(req_write), .req_sec(req_sec), .req_addr(req_addr), .req_wdata(req_wdata),
        .rsp_rdata(rsp[2]), .grp_valid(gv[2]), .grp_write(gw[2]), .grp_addr(ga[2]),
        .grp_wdata(gwd[2]), .grp_rdata(grd[2]));

    int n_chk  = 0;
    int n_fail = 0;
    bit done   = 1'b0;

    task automatic chk(input string tag, input logic [65:0] act, input logic [65:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic drive(input logic v, input logic w, input logic [1:0] s,
                         input logic [11:0] a, input logic [63:0] d);
        @(negedge clk);
        req_valid = v; req_write = w; req_sec = s; req_addr = a; req_wdata = d;
        #2;
    endtask

    function automatic logic [5:0] stored(input int k, input logic [5:0] c);
        return (k == 0) ? c : {4'b0000, c[1:0]};
    endfunction

    function automatic int lvl_of(input logic [1:0] code);
        return (code == 2'b11) ? 2 : (code == 2'b01) ? 1 : 0;
    endfunction

    // 0 blocked, 1 read-only, 2 read-write
    function automatic int exp_lvl(input int k, input logic [5:0] c, input logic [1:0] s);
        if (s == 2'b11) return 2;
        if (k == 0) return lvl_of(s == 2'b00 ? c[1:0] : s == 2'b01 ? c[3:2] : c[5:4]);
        if (k == 1) return lvl_of(c[1:0]);
        if (s == 2'b00) return lvl_of(c[1:0]);
        if (s == 2'b01) return 2;
        return 0;
    endfunction

    function automatic logic cfg_owner(input int k, input logic [1:0] s);
        return (s == 2'b11) || (k == 2 && s == 2'b01);
    endfunction

    function automatic string lvl_tag(input int k, input logic [5:0] c, input logic [1:0] s);
        int l;
        if (s == 2'b11) return "R5";
        if (k == 1) return "R8";
        if (k == 2) return "R11";
        l = exp_lvl(k, c, s);
        return (l == 2) ? "R4" : (l == 1) ? "R3" : "R2";
    endfunction

    function automatic logic [63:0] gdat(input int k, input logic [11:0] a);
        return {16'hBEE0, 14'h0, 2'(k), 20'h0, a};
    endfunction

    function automatic logic [63:0] cfg_val(input int k, input logic [31:0] hi, input logic [5:0] c);
        return {hi, 1'b1, 25'd0, stored(k, c)};
    endfunction

    // all per-state checks for one stored configuration
    task automatic sweep_states(input logic [5:0] c, input logic [31:0] hi);
        for (int s = 0; s < 4; s++) begin
            drive(1'b1, 1'b0, 2'(s), CFG, 64'd0);
            for (int k = 0; k < 3; k++)
                chk($sformatf("%s inst%0d sec%0d cfg read c=%0h",
                        cfg_owner(k, 2'(s)) ? ((c[3] & ~c[2]) | (c[1] & ~c[0]) | (c[5] & ~c[4]) ? "R12" : "R6") : "R7",
                        k, s, c),
                    {gv[k], gw[k], rsp[k]},
                    {2'b00, cfg_owner(k, 2'(s)) ? cfg_val(k, hi, c) : 64'd0});
            drive(1'b1, 1'b0, 2'(s), GUARD, 64'd0);
            for (int k = 0; k < 3; k++) begin
                int l = exp_lvl(k, c, 2'(s));
                chk($sformatf("%s inst%0d sec%0d guarded read c=%0h", lvl_tag(k, c, 2'(s)), k, s, c),
                    {gv[k], gw[k], rsp[k]},
                    (l > 0) ? {2'b10, gdat(k, GUARD)} : 66'd0);
            end
            drive(1'b1, 1'b1, 2'(s), GUARD + 12'h100, 64'h1234);
            for (int k = 0; k < 3; k++) begin
                int l = exp_lvl(k, c, 2'(s));
                chk($sformatf("%s inst%0d sec%0d guarded write c=%0h", lvl_tag(k, c, 2'(s)), k, s, c),
                    {gv[k], gw[k], rsp[k]},
                    (l == 2) ? {2'b11, 64'd0} : 66'd0);
            end
            drive(1'b1, 1'b0, 2'(s), STAT, 64'd0);
            for (int k = 0; k < 3; k++) begin
                logic ok = !(k == 2 && s == 2);
                chk($sformatf("R9 inst%0d sec%0d status read c=%0h", k, s, c),
                    {gv[k], gw[k], rsp[k]},
                    ok ? {2'b10, gdat(k, STAT)} : 66'd0);
            end
        end
    endtask

    task automatic finish_up;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    endtask

    initial begin
        #(8 * 200000);
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog expired actual=running expected=finished");
            finish_up();
        end
    end

    initial begin
        logic [31:0] hi;
        rst_n = 1'b0; recov_clr = 1'b0;
        req_valid = 1'b0; req_write = 1'b0; req_sec = 2'b00; req_addr = '0; req_wdata = '0;
        repeat (3) @(posedge clk);
        @(negedge clk); rst_n = 1'b1;

        // R1: reset contents, observed by the owner
        drive(1'b1, 1'b0, 2'b11, CFG, 64'd0);
        for (int k = 0; k < 3; k++)
            chk($sformatf("R1 inst%0d reset value", k), {gv[k], gw[k], rsp[k]},
                {2'b00, cfg_val(k, 32'd0, RSTP)});
        // R1: reset code 11 lets Non-secure write through
        drive(1'b1, 1'b1, 2'b00, GUARD, 64'd5);
        for (int k = 0; k < 3; k++)
            chk($sformatf("R1 inst%0d reset perm ns write", k), {gv[k], gw[k], rsp[k]}, {2'b11, 64'd0});

        // R7: Non-secure write to the permission word is ignored
        drive(1'b1, 1'b1, 2'b00, CFG, 64'hFFFF_FFFF_FFFF_FFC0);
        drive(1'b1, 1'b0, 2'b11, CFG, 64'd0);
        for (int k = 0; k < 3; k++)
            chk($sformatf("R7 inst%0d ns write ignored", k), {gv[k], gw[k], rsp[k]},
                {2'b00, cfg_val(k, 32'd0, RSTP)});
        // R7: Secure write reaches only the no-realm instance
        drive(1'b1, 1'b1, 2'b01, CFG, {32'hABCD_0000, 32'h0000_0001});
        drive(1'b1, 1'b0, 2'b11, CFG, 64'd0);
        chk("R7 inst0 secure write ignored", {gv[0], gw[0], rsp[0]}, {2'b00, cfg_val(0, 32'd0, RSTP)});
        chk("R7 inst1 secure write ignored", {gv[1], gw[1], rsp[1]}, {2'b00, cfg_val(1, 32'd0, RSTP)});
        chk("R11 inst2 secure owns word", {gv[2], gw[2], rsp[2]}, {2'b00, cfg_val(2, 32'hABCD_0000, 6'b000001)});

        // full sweep of every code combination
        hi = 32'd0;
        for (int c = 0; c < 64; c++) begin
            hi = 32'h5000_0000 | 32'(c * 32'h0101);
            drive(1'b1, 1'b1, 2'b11, CFG, {hi, 1'b0, 25'h1FF_FFFF, 6'(c)});
            for (int k = 0; k < 3; k++)
                chk($sformatf("R10 inst%0d cfg write not forwarded c=%0h", k, c),
                    {gv[k], gw[k], rsp[k]}, 66'd0);
            sweep_states(6'(c), hi);
        end

        // R1: error-recovery pulse reloads only the permission bits
        drive(1'b0, 1'b0, 2'b00, '0, 64'd0);
        recov_clr = 1'b1;
        @(negedge clk); recov_clr = 1'b0;
        drive(1'b1, 1'b0, 2'b11, CFG, 64'd0);
        for (int k = 0; k < 3; k++)
            chk($sformatf("R1 inst%0d recovery reload", k), {gv[k], gw[k], rsp[k]},
                {2'b00, cfg_val(k, hi, RSTP)});

        // R10: idle cycle is quiet
        drive(1'b0, 1'b0, 2'b11, GUARD, 64'd0);
        for (int k = 0; k < 3; k++)
            chk($sformatf("R10 inst%0d idle", k), {gv[k], gw[k], rsp[k]}, 66'd0);

        done = 1'b1;
        finish_up();
    end

endmodule